// File: doc/BRIEF.md
# Parking Arbiter for a Shared Peripheral Bus

This block decides which of several masters owns a synchronous peripheral bus with 32-bit address and data paths. Each master has a request line, a select line that marks a transfer beat, a sequential-burst continuation flag, and its own address, write data and transfer size. The owner's address, data and size are routed onto the shared bus outputs. When nobody asks for the bus, the grant stays on the last master that finished a beat. That master can start its next beat in the same cycle, with no request and no wait for arbitration.

Requests are served in fixed priority order, and the lowest index wins. A beat that carries the continuation flag locks the grant for the next cycle, so a sequential burst is never split. The block also checks every beat. It raises one flag when the address does not suit the transfer size, and another when a burst beat does not follow on from the address of the previous beat.

Top module: `abus_park_arb`

## Requirements
- R1: While reset is asserted, `gnt_o` is one-hot on master 0. With every select low, `busy_o`, `mis_err_o` and `seq_err_o` are 0.
- R2: When the granted master asserts its select bit, `busy_o` is 1 in that same cycle, with no request needed. In the same cycle, `addr_o`, `wdata_o` and `size_o` carry that master's values.
- R3: A select bit from a master that does not hold the grant is ignored. `busy_o` stays 0 and no error flag rises.
- R4: After any cycle that is not a held burst beat and in which no request bit is set, the grant parks on the last master that completed a beat. That master is 0 if no beat has completed since reset.
- R5: After any cycle that is not a held burst beat and in which one or more request bits are set, the grant moves to the lowest-indexed requesting master.
- R6: A beat with the owner's `seq_i` bit set keeps `gnt_o` unchanged in the next cycle, whatever the requests.
- R7: Size codes are 2'b00 for byte, 2'b01 for half-word, 2'b10 for word and 2'b11 for reserved. During a beat, `mis_err_o` is 1 in the same cycle if the size is half-word with address bit 0 set, word with address bits 1:0 nonzero, or the reserved code.
- R8: For a beat that directly follows a beat with `seq_i` set, the expected address is the previous address plus 1, 2 or 4 bytes, taken from the previous size (the reserved code counts as 4). If the address differs, `seq_err_o` is 1 in that beat's cycle.
- R9: `gnt_o` is always exactly one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_MASTERS | Per-master bus request |
| sel_i | input | NUM_MASTERS | Per-master transfer beat strobe |
| seq_i | input | NUM_MASTERS | Per-master burst continuation flag |
| addr_i | input | NUM_MASTERS*ADDR_W | Packed per-master addresses, master m at bits m*ADDR_W |
| wdata_i | input | NUM_MASTERS*DATA_W | Packed per-master write data |
| size_i | input | NUM_MASTERS*2 | Packed per-master size codes |
| gnt_o | output | NUM_MASTERS | One-hot grant |
| busy_o | output | 1 | A beat by the owner is on the bus |
| addr_o | output | ADDR_W | Owner's address |
| wdata_o | output | DATA_W | Owner's write data |
| size_o | output | 2 | Owner's size code |
| mis_err_o | output | 1 | Misaligned or reserved-size beat |
| seq_err_o | output | 1 | Burst beat off the sequential address |

## Verification
Two events can land in one cycle: the parked master starts a beat without requesting, and another master raises a request. The bus must accept the beat at once, then hand the grant to the requester on the next edge. A burst beat with its continuation flag set can meet a higher-priority request in the same cycle. There the request must wait and the grant must stay put. Directed sequences create both collisions on purpose, and seeded random stimulus repeats them many times. A bench model built from the requirements judges every cycle: it predicts the grant, busy and both error flags.

// File: rtl/abus_pkg.sv
package abus_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } xfer_size_e;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_HALF: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/abus_prio_pick.sv
module abus_prio_pick #(
   parameter int NUM_MASTERS = 4,
   localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic [NUM_MASTERS-1:0] req_i,
   output logic                   any_o,
   output logic [IDX_W-1:0]       idx_o
);
   always_comb begin
      idx_o = '0;
      for (int m = NUM_MASTERS - 1; m >= 0; m--) begin
         if (req_i[m]) idx_o = IDX_W'(m);
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/abus_align_chk.sv
module abus_align_chk #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   output logic              mis_o
);
   import abus_pkg::*;

   always_comb begin
      case (xfer_size_e'(size_i))
         SZ_BYTE: mis_o = 1'b0;
         SZ_HALF: mis_o = addr_i[0];
         SZ_WORD: mis_o = |addr_i[1:0];
         default: mis_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/abus_burst_track.sv
module abus_burst_track #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_i,
   input  logic              hold_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   output logic              seq_err_o
);
   import abus_pkg::*;

   logic [ADDR_W-1:0] next_addr_q;
   logic              in_burst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_addr_q <= '0;
         in_burst_q  <= 1'b0;
      end else begin
         in_burst_q <= hold_i;
         if (beat_i) next_addr_q <= addr_i + ADDR_W'(size_bytes(size_i));
      end
   end

   assign seq_err_o = beat_i & in_burst_q & (addr_i != next_addr_q);
endmodule

// File: rtl/abus_park_arb.sv
module abus_park_arb #(
   parameter int NUM_MASTERS  = 4,
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter bit PARK_ON_LAST = 1'b1,
   localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_MASTERS-1:0]        req_i,
   input  logic [NUM_MASTERS-1:0]        sel_i,
   input  logic [NUM_MASTERS-1:0]        seq_i,
   input  logic [NUM_MASTERS*ADDR_W-1:0] addr_i,
   input  logic [NUM_MASTERS*DATA_W-1:0] wdata_i,
   input  logic [NUM_MASTERS*2-1:0]      size_i,
   output logic [NUM_MASTERS-1:0]        gnt_o,
   output logic                          busy_o,
   output logic [ADDR_W-1:0]             addr_o,
   output logic [DATA_W-1:0]             wdata_o,
   output logic [1:0]                    size_o,
   output logic                          mis_err_o,
   output logic                          seq_err_o
);
   initial begin
      assert (NUM_MASTERS >= 2) else $error("NUM_MASTERS must be at least 2");
      assert (ADDR_W >= 8) else $error("ADDR_W must be at least 8");
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
   end

   logic [ADDR_W-1:0] addr_arr  [NUM_MASTERS];
   logic [DATA_W-1:0] wdata_arr [NUM_MASTERS];
   logic [1:0]        size_arr  [NUM_MASTERS];

   logic [IDX_W-1:0] owner_q, owner_d, last_q, last_d, pick_idx, park_idx;
   logic             any_req, held, mis;

   for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_lane
      assign addr_arr[g]  = addr_i[g*ADDR_W +: ADDR_W];
      assign wdata_arr[g] = wdata_i[g*DATA_W +: DATA_W];
      assign size_arr[g]  = size_i[g*2 +: 2];
      assign gnt_o[g]     = (owner_q == IDX_W'(g));
   end

   assign addr_o  = addr_arr[owner_q];
   assign wdata_o = wdata_arr[owner_q];
   assign size_o  = size_arr[owner_q];
   assign busy_o  = sel_i[owner_q];
   assign held    = busy_o & seq_i[owner_q];
   assign last_d  = busy_o ? owner_q : last_q;

   if (PARK_ON_LAST) begin : g_park_last
      assign park_idx = last_d;
   end else begin : g_park_zero
      assign park_idx = '0;
   end

   abus_prio_pick #(.NUM_MASTERS(NUM_MASTERS)) pick_i (
      .req_i (req_i),
      .any_o (any_req),
      .idx_o (pick_idx)
   );

   always_comb begin
      if (held)         owner_d = owner_q;
      else if (any_req) owner_d = pick_idx;
      else              owner_d = park_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= '0;
         last_q  <= '0;
      end else begin
         owner_q <= owner_d;
         last_q  <= last_d;
      end
   end

   abus_align_chk #(.ADDR_W(ADDR_W)) align_i (
      .addr_i (addr_o),
      .size_i (size_o),
      .mis_o  (mis)
   );
   assign mis_err_o = busy_o & mis;

   abus_burst_track #(.ADDR_W(ADDR_W)) burst_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_i    (busy_o),
      .hold_i    (held),
      .addr_i    (addr_o),
      .size_i    (size_o),
      .seq_err_o (seq_err_o)
   );
endmodule

// File: rtl/abus_park_arb_chk.sv
module abus_park_arb_chk #(
   parameter int NUM_MASTERS  = 4,
   parameter bit PARK_ON_LAST = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_MASTERS-1:0] req_i,
   input logic [NUM_MASTERS-1:0] sel_i,
   input logic [NUM_MASTERS-1:0] seq_i,
   input logic [NUM_MASTERS-1:0] gnt_o,
   input logic                   busy_o,
   input logic                   mis_err_o,
   input logic                   seq_err_o
);
   logic hold_now;
   assign hold_now = busy_o && |(gnt_o & seq_i);

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt_o) == 1); // R9

   AST_BUSY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> |(gnt_o & sel_i)); // R2

   AST_FOREIGN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(gnt_o & sel_i)) |-> !busy_o && !mis_err_o && !seq_err_o); // R3

   AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hold_now |=> $stable(gnt_o)); // R6

   AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_now && req_i[0] |=> gnt_o[0]); // R5

   AST_MIS_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      mis_err_o |-> busy_o); // R7

   AST_SEQ_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err_o |-> busy_o); // R8

   if (PARK_ON_LAST) begin : g_park_chk
      AST_PARK_STAY: assert property (@(posedge clk) disable iff (!rst_n)
         busy_o && !(|req_i) |=> $stable(gnt_o)); // R4
   end
endmodule

bind abus_park_arb abus_park_arb_chk #(
   .NUM_MASTERS  (NUM_MASTERS),
   .PARK_ON_LAST (PARK_ON_LAST)
) chk_i (.*);

// File: tb/abus_park_arb_tb_top.sv
module abus_park_arb_tb_top;
   localparam int NM = 4;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int RAND_CYCLES = 3000;
   localparam int WATCHDOG_CYCLES = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NM-1:0]    req = '0, sel = '0, seq = '0;
   logic [NM*AW-1:0] addr = '0;
   logic [NM*DW-1:0] wdata = '0;
   logic [NM*2-1:0]  size = '0;
   logic [NM-1:0]    gnt;
   logic             busy, mis_err, seq_err;
   logic [AW-1:0]    addr_o;
   logic [DW-1:0]    wdata_o;
   logic [1:0]       size_o;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int        m_own = 0, m_last = 0;
   bit        m_inb = 1'b0;
   logic [AW-1:0] m_exp = '0;

   always #5 clk = ~clk;

   abus_park_arb #(.NUM_MASTERS(NM), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .sel_i(sel), .seq_i(seq),
      .addr_i(addr), .wdata_i(wdata), .size_i(size), .gnt_o(gnt),
      .busy_o(busy), .addr_o(addr_o), .wdata_o(wdata_o), .size_o(size_o),
      .mis_err_o(mis_err), .seq_err_o(seq_err)
   );

   function automatic bit f_mis(input logic [AW-1:0] a, input logic [1:0] s);
      if (s == 2'b00) return 1'b0;
      if (s == 2'b01) return a[0];
      if (s == 2'b10) return a[1:0] != 2'b00;
      return 1'b1;
   endfunction

   function automatic logic [AW-1:0] f_step(input logic [1:0] s);
      return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
   endfunction

   function automatic int f_pick(input logic [NM-1:0] r);
      for (int m = 0; m < NM; m++) if (r[m]) return m;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_m(input int m, input logic [AW-1:0] a, input logic [1:0] s);
      addr[m*AW +: AW]  = a;
      size[m*2 +: 2]    = s;
      wdata[m*DW +: DW] = $urandom;
   endtask

   // Inputs are set at posedge+1; outputs are judged at posedge+3, then grant after the edge.
   task automatic step();
      bit b, h, me, se;
      logic [AW-1:0] a;
      logic [1:0] s;
      int nxt;
      #2;
      a  = addr[m_own*AW +: AW];
      s  = size[m_own*2 +: 2];
      b  = sel[m_own];
      h  = b && seq[m_own];
      me = b && f_mis(a, s);
      se = b && m_inb && (a != m_exp);
      chk(busy == b, (b || sel == '0) ? "R2 busy" : "R3 foreign sel busy", 64'(busy), 64'(b));
      if (b) begin
         chk(addr_o == a, "R2 addr_o", 64'(addr_o), 64'(a));
         chk(wdata_o == wdata[m_own*DW +: DW], "R2 wdata_o", 64'(wdata_o), 64'(wdata[m_own*DW +: DW]));
         chk(size_o == s, "R2 size_o", 64'(size_o), 64'(s));
      end
      chk(mis_err == me, b ? "R7 mis_err" : "R3 mis_err idle", 64'(mis_err), 64'(me));
      chk(seq_err == se, b ? "R8 seq_err" : "R3 seq_err idle", 64'(seq_err), 64'(se));
      if (b) m_last = m_own;
      if (h) nxt = m_own;
      else if (req != '0) nxt = f_pick(req);
      else nxt = m_last;
      m_inb = h;
      if (b) m_exp = a + f_step(s);
      @(posedge clk);
      #1;
      chk(gnt == NM'(1 << nxt), h ? "R6 burst hold" : (req != '0) ? "R5 priority grant" : "R4 park grant",
          64'(gnt), 64'(1 << nxt));
      chk($countones(gnt) == 1, "R9 onehot", 64'(gnt), 64'(1 << nxt));
      m_own = nxt;
   endtask

   task automatic idle_inputs();
      req = '0; sel = '0; seq = '0;
   endtask

   initial begin
      void'($urandom(32'h5EED_2024));
      repeat (3) @(posedge clk);
      #3;
      chk(gnt == 4'b0001, "R1 reset grant", 64'(gnt), 64'h1);
      chk(busy == 1'b0, "R1 reset busy", 64'(busy), 64'h0);
      chk(mis_err == 1'b0 && seq_err == 1'b0, "R1 reset errors", 64'({mis_err, seq_err}), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // Idle: stays parked on master 0
      idle_inputs(); step();
      // Parked master 0 starts a word beat with no request
      set_m(0, 32'h100, 2'b10); sel = 4'b0001; step();
      // Master 2 selects without grant: ignored
      idle_inputs(); set_m(2, 32'h3, 2'b11); sel = 4'b0100; step();
      // Master 0 beats while master 2 requests in the same cycle
      idle_inputs(); set_m(0, 32'h104, 2'b10); sel = 4'b0001; req = 4'b0100; step();
      // Master 2 beats, then nobody requests: park on 2
      idle_inputs(); set_m(2, 32'h200, 2'b10); sel = 4'b0100; step();
      idle_inputs(); step();
      idle_inputs(); step();
      // Priority: 1 and 3 request, 1 wins
      req = 4'b1010; step();
      // Burst by master 1 against a master 0 request
      idle_inputs(); req = 4'b0001; sel = 4'b0010; seq = 4'b0010; set_m(1, 32'h10, 2'b01); step();
      set_m(1, 32'h12, 2'b01); step();
      seq = 4'b0000; set_m(1, 32'h15, 2'b01); step();
      // Master 0 misaligned cases
      idle_inputs(); sel = 4'b0001; set_m(0, 32'h3, 2'b01); step();
      set_m(0, 32'h2, 2'b10); step();
      set_m(0, 32'h0, 2'b11); step();
      set_m(0, 32'h7, 2'b00); step();
      idle_inputs(); step();

      for (int i = 0; i < RAND_CYCLES; i++) begin
         req = '0; sel = '0; seq = '0;
         for (int m = 0; m < NM; m++) begin
            logic [1:0] s;
            logic [AW-1:0] a;
            req[m] = ($urandom % 100) < 20;
            sel[m] = ($urandom % 100) < ((m == m_own) ? 60 : 20);
            seq[m] = ($urandom % 100) < 50;
            s = (($urandom % 10) == 0) ? 2'b11 : 2'($urandom % 3);
            a = $urandom;
            if (($urandom % 100) < 80) a = a & ~32'h3;
            if (m == m_own && m_inb && ($urandom % 100) < 75) a = m_exp;
            set_m(m, a, s);
         end
         step();
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_CYCLES, RAND_CYCLES);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule